// File: doc/BRIEF.md
# Serial Video Word Aligner

This block sits after the descrambler in a serial digital video receiver. It takes a bit stream, one bit on each cycle where a bit enable is high, and rebuilds the 10-bit parallel words. It watches a sliding 30-bit window for the timing reference preamble: one all-ones word followed by two all-zeros words. It places the word boundary on that preamble. Bits travel least significant first.

The block delivers four outputs. The first is a one-cycle word strobe. The second is the parallel word. The third is a parallel clock level whose rising edge sits mid-word. The fourth is a line-sync output that changes level once per accepted preamble, one word period before the all-ones word reaches the parallel output. A sync-error pulse marks any preamble found off the current boundary.

A correction-enable input selects how the block reacts to one stray preamble. When correction is enabled, a single off-boundary preamble is reported but does not move the boundary. A second off-boundary preamble in a row does move it.

Top module: `sdi_word_aligner`

## Requirements
- R1: While and after reset, before any bit is accepted, word_out is 0 and word_en, pclk, hsync and sync_err are all 0.
- R2: A preamble is detected on an accepted bit when the most recent 30 accepted bits consist of 10 ones followed by 20 zeros, in arrival order.
- R3: word_en is a single-cycle strobe that marks every word boundary. word_out changes only in the cycle where word_en is high. With a steady boundary, a strobe follows every tenth accepted bit.
- R4: At each boundary, the ten oldest bits of the 30-bit window are captured with the earliest-arrived bit as bit 0. They appear on word_out at the following boundary. With a steady boundary this gives three words of latency.
- R5: The first preamble after reset always sets the boundary, so that its last bit ends a word. This holds at any setting of corr_en, and it raises no sync_err.
- R6: With corr_en low, a preamble off the current boundary pulses sync_err in the next cycle and moves the boundary to the preamble immediately.
- R7: With corr_en high and no misalignment pending, an off-boundary preamble pulses sync_err. It leaves the boundary, the word strobe and hsync unchanged, and it marks a misalignment as pending.
- R8: With corr_en high and a misalignment pending, the next off-boundary preamble pulses sync_err and moves the boundary. A preamble on the boundary clears the pending state.
- R9: hsync inverts in the same cycle as the word_en strobe of each boundary where a preamble is accepted, whether on the boundary or newly moved to it. The next word_en then presents 10'h3FF on word_out.
- R10: pclk is low from each boundary until five further bits have been accepted, then high until the next boundary. Its rising edge therefore sits mid-word and its falling edge on the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies bit_in as a new serial bit |
| bit_in | input | 1 | Descrambled serial data bit |
| corr_en | input | 1 | High: one stray preamble cannot move the boundary |
| word_en | output | 1 | One-cycle strobe at each word boundary |
| word_out | output | 10 | Aligned parallel word, bit 0 received first |
| pclk | output | 1 | Parallel clock level, rising mid-word |
| hsync | output | 1 | Inverts once per accepted preamble |
| sync_err | output | 1 | One-cycle pulse for an off-boundary preamble |

## Verification
The hardest case to reach is a misalignment left pending and then cleared before a second stray preamble arrives. That case needs a preamble shifted by a few bits, a return to the original phase, and then another shifted preamble. Directed sequences reach it by inserting runs of zero padding bits between fixed filler words and preambles, so the offset of each preamble from the boundary is known exactly. Random traffic follows, with gaps in bit_en, random offsets and random corr_en, compared against a bench model bit by bit.

// File: rtl/sdi_align_pkg.sv
package sdi_align_pkg;
  parameter int unsigned DEF_WORD_W = 10;

  // decision taken on a preamble hit
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,  // no preamble this bit
    ACT_KEEP = 2'd1,  // preamble on current boundary
    ACT_HOLD = 2'd2,  // stray preamble, boundary kept
    ACT_MOVE = 2'd3   // boundary re-timed to preamble
  } sync_act_e;
endpackage

// File: rtl/sdi_shift_det.sv
module sdi_shift_det #(
  parameter int unsigned WORD_W = sdi_align_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic              sync_hit,
  output logic [WORD_W-1:0] old_word
);
  localparam int unsigned SR_W = 3 * WORD_W;

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_nxt;

  // oldest word in low bits, its first bit at bit 0
  function automatic logic preamble_match(input logic [SR_W-1:0] win);
    return (win[WORD_W-1:0] == {WORD_W{1'b1}}) && (win[SR_W-1:WORD_W] == '0);
  endfunction

  assign sr_nxt   = {bit_in, sr_q[SR_W-1:1]};
  assign sync_hit = bit_en && preamble_match(sr_nxt);
  assign old_word = sr_nxt[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)      sr_q <= '0;
    else if (bit_en) sr_q <= sr_nxt;
  end
endmodule

// File: rtl/sdi_align_ctrl.sv
module sdi_align_ctrl
  import sdi_align_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic sync_hit,
  input  logic corr_en,
  output logic at_bound,
  output logic word_done,
  output logic toggle,
  output logic locked,
  output logic pending,
  output logic err_pulse,
  output logic pclk
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam int unsigned HALF  = WORD_W / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;
  sync_act_e        act;

  function automatic logic [CNT_W-1:0] phase_step(input logic [CNT_W-1:0] p,
                                                  input logic en,
                                                  input logic wrap);
    if (wrap)    return '0;
    else if (en) return p + 1'b1;
    else         return p;
  endfunction

  function automatic sync_act_e decide(input logic hit, input logic lk,
                                       input logic bnd, input logic ce,
                                       input logic pend);
    if (!hit)            return ACT_NONE;
    else if (!lk)        return ACT_MOVE;
    else if (bnd)        return ACT_KEEP;
    else if (!ce || pend) return ACT_MOVE;
    else                 return ACT_HOLD;
  endfunction

  assign at_bound  = bit_en && (cnt_q == LAST);
  assign act       = decide(sync_hit, locked, at_bound, corr_en, pending);
  assign word_done = at_bound || (act == ACT_MOVE);
  assign toggle    = (act == ACT_KEEP) || (act == ACT_MOVE);
  assign pclk      = (cnt_q >= CNT_W'(HALF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      locked    <= 1'b0;
      pending   <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      cnt_q     <= phase_step(cnt_q, bit_en, word_done);
      err_pulse <= sync_hit && locked && !at_bound;
      if (sync_hit) locked <= 1'b1;
      case (act)
        ACT_HOLD:           pending <= 1'b1;
        ACT_KEEP, ACT_MOVE: pending <= 1'b0;
        default:            pending <= pending;
      endcase
    end
  end
endmodule

// File: rtl/sdi_word_out.sv
module sdi_word_out #(
  parameter int unsigned WORD_W = sdi_align_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic              toggle,
  input  logic [WORD_W-1:0] old_word,
  output logic [WORD_W-1:0] word_out,
  output logic              word_en,
  output logic              hsync
);
  logic [WORD_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q  <= '0;
      word_out <= '0;
      word_en  <= 1'b0;
      hsync    <= 1'b0;
    end else begin
      word_en <= word_done;
      if (word_done) begin
        stage_q  <= old_word;
        word_out <= stage_q;
      end
      if (toggle) hsync <= ~hsync;
    end
  end
endmodule

// File: rtl/sdi_word_aligner.sv
module sdi_word_aligner #(
  parameter int unsigned WORD_W = sdi_align_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              corr_en,
  output logic              word_en,
  output logic [WORD_W-1:0] word_out,
  output logic              pclk,
  output logic              hsync,
  output logic              sync_err
);
  logic              sync_hit;
  logic [WORD_W-1:0] old_word;
  logic              at_bound;
  logic              word_done;
  logic              toggle;
  logic              locked;
  logic              pending;

  sdi_shift_det #(.WORD_W(WORD_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .sync_hit (sync_hit),
    .old_word (old_word)
  );

  sdi_align_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .sync_hit  (sync_hit),
    .corr_en   (corr_en),
    .at_bound  (at_bound),
    .word_done (word_done),
    .toggle    (toggle),
    .locked    (locked),
    .pending   (pending),
    .err_pulse (sync_err),
    .pclk      (pclk)
  );

  sdi_word_out #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_done (word_done),
    .toggle    (toggle),
    .old_word  (old_word),
    .word_out  (word_out),
    .word_en   (word_en),
    .hsync     (hsync)
  );
endmodule

// File: rtl/sdi_word_aligner_chk.sv
module sdi_word_aligner_chk #(
  parameter int unsigned WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              corr_en,
  input logic              word_en,
  input logic [WORD_W-1:0] word_out,
  input logic              pclk,
  input logic              hsync,
  input logic              sync_err,
  input logic              sync_hit,
  input logic              at_bound,
  input logic              locked,
  input logic              pending
);
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_en |-> $stable(word_out)); // R3

  AST_FIRST_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && sync_hit) |=> (!sync_err && word_en)); // R5

  AST_MOVE_NOCORR: assert property (@(posedge clk) disable iff (!rst_n)
    (!corr_en && locked && sync_hit && !at_bound) |=> (word_en && sync_err && (hsync != $past(hsync)))); // R6

  AST_CORR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_en && locked && !pending && sync_hit && !at_bound) |=> (!word_en && sync_err && $stable(hsync))); // R7

  AST_SECOND_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_en && pending && sync_hit && !at_bound) |=> (word_en && sync_err)); // R8

  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> $past(sync_hit && locked && !at_bound)); // R7

  AST_HS_AT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync != $past(hsync)) |-> word_en); // R9

  AST_PCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    word_en |-> !pclk); // R10
endmodule

bind sdi_word_aligner sdi_word_aligner_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .corr_en  (corr_en),
  .word_en  (word_en),
  .word_out (word_out),
  .pclk     (pclk),
  .hsync    (hsync),
  .sync_err (sync_err),
  .sync_hit (sync_hit),
  .at_bound (at_bound),
  .locked   (locked),
  .pending  (pending)
);

// File: tb/sdi_word_aligner_tb.sv
module sdi_word_aligner_tb;
  localparam int CLK_P = 10;
  localparam logic [9:0] FILL = 10'h155;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic bit_in = 1'b0;
  logic corr_en = 1'b0;
  logic word_en, pclk, hsync, sync_err;
  logic [9:0] word_out;

  int n_chk = 0, n_fail = 0;
  int err_seen = 0, tog_seen = 0;
  logic prev_hs = 1'b0;
  logic want_3ff = 1'b0;
  bit done = 0;

  // bench model state
  logic [29:0] hist = '0;  // newest bit at bit 0
  int m_cnt = 0;
  logic m_lock = 0, m_pend = 0, m_hs = 0;
  logic [9:0] m_stage = '0, m_word = '0;

  always #(CLK_P/2) clk = ~clk;

  sdi_word_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .corr_en(corr_en), .word_en(word_en), .word_out(word_out),
    .pclk(pclk), .hsync(hsync), .sync_err(sync_err)
  );

  function automatic logic [9:0] flip10(input logic [9:0] v);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = v[9-i];
    return r;
  endfunction

  function automatic logic is_preamble(input logic [29:0] h);
    return (h[29:20] == 10'h3FF) && (h[19:0] == 20'd0);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic b);
    logic e_en, e_err, hit, bnd, mv, hd;
    @(negedge clk);
    bit_en = en; bit_in = b;
    e_en = 0; e_err = 0;
    if (en) begin
      hist = {hist[28:0], b};
      hit  = is_preamble(hist);
      bnd  = (m_cnt == 9);
      mv   = hit && (!m_lock || (!bnd && (!corr_en || m_pend)));
      hd   = hit && m_lock && !bnd && corr_en && !m_pend;
      e_err = hit && m_lock && !bnd;
      if (hit && (bnd || mv)) begin m_hs = ~m_hs; m_pend = 0; end
      if (hd) m_pend = 1;
      if (bnd || mv) begin
        m_word = m_stage; m_stage = flip10(hist[29:20]); e_en = 1; m_cnt = 0;
      end else m_cnt++;
      if (hit) m_lock = 1;
    end
    @(posedge clk);
    #(CLK_P/4);
    chk(word_en === e_en, "R3 word_en", word_en, e_en);
    chk(word_out === m_word, "R4 word_out", word_out, m_word);
    chk(sync_err === e_err, "R2/R6/R7/R8 sync_err", sync_err, e_err);
    chk(hsync === m_hs, "R9 hsync", hsync, m_hs);
    chk(pclk === (m_cnt >= 5), "R10 pclk", pclk, m_cnt >= 5);
    if (word_en && want_3ff) begin
      chk(word_out === 10'h3FF, "R9 3FF after hsync", word_out, 10'h3FF);
      want_3ff = 0;
    end
    if (hsync !== prev_hs) begin tog_seen++; want_3ff = 1; end
    prev_hs = hsync;
    if (sync_err) err_seen++;
  endtask

  task automatic send_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) step(1'b1, w[i]);
  endtask

  task automatic send_pre();
    send_word(10'h3FF); send_word(10'h000); send_word(10'h000);
  endtask

  task automatic pad(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0);
  endtask

  task automatic expect_delta(input int e0, input int t0, input int de, input int dt, input string tag);
    chk(err_seen - e0 == de, {tag, " error count"}, err_seen - e0, de);
    chk(tog_seen - t0 == dt, {tag, " hsync toggles"}, tog_seen - t0, dt);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int e0, t0;
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(word_out === 10'd0 && !word_en && !pclk && !hsync && !sync_err,
        "R1 reset outputs", {word_en, pclk, hsync, sync_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0);
    chk(word_out === 10'd0 && !word_en && !pclk && !hsync && !sync_err,
        "R1 after reset", {word_en, pclk, hsync, sync_err}, 0);

    // R5: first preamble sets boundary, corr_en high
    corr_en = 1'b1;
    pad(2); send_word(FILL); send_word(FILL);
    e0 = err_seen; t0 = tog_seen;
    send_pre();
    expect_delta(e0, t0, 0, 1, "R5 first lock");
    send_word(FILL); send_word(FILL);
    e0 = err_seen; t0 = tog_seen;
    send_pre();
    expect_delta(e0, t0, 0, 1, "R2 aligned preamble");

    // R7 then R8: two stray preambles in a row
    pad(3);
    e0 = err_seen; t0 = tog_seen;
    send_pre();
    expect_delta(e0, t0, 1, 0, "R7 stray held");
    e0 = err_seen; t0 = tog_seen;
    send_pre();
    expect_delta(e0, t0, 1, 1, "R8 second stray moves");
    send_word(FILL);
    e0 = err_seen; t0 = tog_seen;
    send_pre();
    expect_delta(e0, t0, 0, 1, "R8 new boundary aligned");

    // R8: aligned preamble clears pending
    pad(3);
    e0 = err_seen; t0 = tog_seen;
    send_pre();
    expect_delta(e0, t0, 1, 0, "R7 stray held again");
    pad(7);
    e0 = err_seen; t0 = tog_seen;
    send_pre();
    expect_delta(e0, t0, 0, 1, "R8 aligned clears pending");
    pad(3);
    e0 = err_seen; t0 = tog_seen;
    send_pre();
    expect_delta(e0, t0, 1, 0, "R8 pending was cleared");
    pad(7);
    send_pre();

    // R6: correction disabled
    corr_en = 1'b0;
    pad(4);
    e0 = err_seen; t0 = tog_seen;
    send_pre();
    expect_delta(e0, t0, 1, 1, "R6 immediate move");
    e0 = err_seen; t0 = tog_seen;
    send_pre();
    expect_delta(e0, t0, 0, 1, "R6 aligned after move");

    // random traffic with bit_en gaps and offsets
    for (int k = 0; k < 400; k++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) begin
        corr_en = $urandom_range(0, 1);
        pad($urandom_range(0, 9));
        send_pre();
      end else if (sel == 1) begin
        send_pre();
      end else begin
        logic [9:0] w;
        w = 10'($urandom());
        for (int i = 0; i < 10; i++) begin
          if ($urandom_range(0, 5) == 0) step(1'b0, 1'b1);
          step(1'b1, w[i]);
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule